// File: doc/BRIEF.md
# Receive Signal Guard: Transition Starvation Detector with Byte Squelch

This block sits between a serial-to-parallel receiver and downstream byte logic. It watches the serial receive bit stream for level changes. When the line stays at one level for a configurable number of bit periods, it raises a loss-of-signal flag. A transition, or an active-high clear, drops the flag and restarts the count.

A second, external active-low signal-present input comes from the optics. While that input is low, the block forces the parallel bytes it delivers to zero. It also moves the byte strobe from the receive timing to the transmit timing, so registers downstream keep seeing byte strobes and are never starved.

Both byte clocks are modelled as single-cycle enables in one clock domain. The parallel byte path carries timing strobes and offers no back-pressure: there is no ready signal. Every forwarded strobe presents a byte on the following cycle, and the consumer must accept it then.

Top module: `rx_signal_guard`

## Requirements
- R1: In reset and right after it, `los_flag` is 0, `byte_tick` is 0, `byte_out` is 0, and the byte timing source is the receive strobe.
- R2: `los_flag` becomes 1 on the cycle after the RUN_LIMIT-th (default 128) consecutive enabled bit that equals the bit before it. The first bit after reset is compared against 0. The flag then stays 1 while no transition occurs.
- R3: A run of RUN_LIMIT-1 equal enabled bits, followed by a different bit, never raises `los_flag`.
- R4: An enabled bit that differs from the previous enabled bit clears `los_flag` on the next cycle and restarts the run at zero.
- R5: `los_clr` high forces `los_flag` to 0 on the next cycle and restarts the run at zero. This holds even when the same cycle would have completed a starved run.
- R6: Cycles with `bit_vld` low are ignored. `bit_in` has no effect on the run or on `los_flag` in those cycles.
- R7: While `sig_present` is 1, a forwarded byte strobe produces `byte_tick` = 1 one cycle later, with `byte_out` equal to the `rx_byte` sampled with that strobe. Between strobes, `byte_out` holds its value.
- R8: While `sig_present` is 0, `byte_out` is 0 from the next cycle on, whatever `rx_byte` carries.
- R9: After `sig_present` falls, receive strobes are still forwarded until the first `tx_byte_tick`. That strobe is forwarded, and from then on only transmit strobes are forwarded.
- R10: After `sig_present` rises again, transmit strobes are still forwarded until the first `rx_byte_tick`. That strobe is forwarded, and from then on only receive strobes are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | Qualifies `bit_in` for one bit period |
| bit_in | input | 1 | Serial receive bit |
| los_clr | input | 1 | Active-high clear of the loss flag |
| sig_present | input | 1 | External signal indication; 0 means the signal is lost |
| rx_byte_tick | input | 1 | Receive-side byte strobe |
| tx_byte_tick | input | 1 | Transmit-side byte strobe |
| rx_byte | input | BYTE_W | Parallel receive byte |
| los_flag | output | 1 | Transition starvation flag |
| byte_out | output | BYTE_W | Squelched parallel byte |
| byte_tick | output | 1 | Forwarded byte strobe, one cycle after its source |

## Verification
The embedded assertions check, on every cycle, the local step rules:
- the flag sets when a full run completes;
- a transition or a clear drops it;
- idle cycles leave the run untouched;
- a lost signal zeroes the byte;
- a byte is captured on a strobe and held between strobes;
- a change of timing source happens only on a strobe of the new source.

Only the bench's scenarios can show the behaviours that span many cycles:
- the exact count of 128 equal bits, against 127 followed by a change;
- the restart of the count after a clear;
- the order in which receive and transmit strobes are forwarded across a complete loss-and-recovery episode.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic {
    SRC_RX = 1'b0,
    SRC_TX = 1'b1
  } tsrc_e;
endpackage

// File: rtl/rsg_run_watch.sv
module rsg_run_watch #(
  parameter int RUN_LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic clr,
  output logic los_o
);
  localparam int CNT_W = (RUN_LIMIT > 2) ? $clog2(RUN_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             prev_q;
  logic             los_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      los_q  <= 1'b0;
    end else begin
      if (bit_vld) prev_q <= bit_in;
      if (clr) begin
        cnt_q <= '0;
        los_q <= 1'b0;
      end else if (bit_vld) begin
        if (bit_in != prev_q) begin
          cnt_q <= '0;
          los_q <= 1'b0;
        end else if (cnt_q == LAST) begin
          los_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign los_o = los_q;

  assert_run_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !clr && bit_in == prev_q && cnt_q == LAST) |=> los_q);
  assert_rise_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> $past(cnt_q) == LAST);
  assert_edge_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !clr && bit_in != prev_q) |=> (!los_q && cnt_q == '0));
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!los_q && cnt_q == '0));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !clr) |=> ($stable(los_q) && $stable(cnt_q)));
endmodule

// File: rtl/rsg_tick_select.sv
module rsg_tick_select
  import rsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sig_present,
  input  logic rx_tick,
  input  logic tx_tick,
  output logic fwd_tick
);
  tsrc_e src_q, src_d;

  always_comb begin
    src_d = src_q;
    if (!sig_present && src_q == SRC_RX && tx_tick)
      src_d = SRC_TX;
    else if (sig_present && src_q == SRC_TX && rx_tick)
      src_d = SRC_RX;
  end

  assign fwd_tick = (src_d == SRC_TX) ? tx_tick : rx_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= SRC_RX;
    else        src_q <= src_d;
  end

  assert_enter_tx_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_TX && $past(src_q) == SRC_RX) |-> $past(tx_tick && !sig_present));
  assert_leave_tx_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_RX && $past(src_q) == SRC_TX) |-> $past(rx_tick && sig_present));
endmodule

// File: rtl/rsg_squelch.sv
module rsg_squelch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_present,
  input  logic              fwd_tick,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              tick_out
);
  logic [BYTE_W-1:0] byte_q;
  logic              tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= fwd_tick;
      if (!sig_present)  byte_q <= '0;
      else if (fwd_tick) byte_q <= byte_in;
    end
  end

  assign byte_out = byte_q;
  assign tick_out = tick_q;

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_present && fwd_tick) |=> (tick_q && byte_q == $past(byte_in)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_present && !fwd_tick) |=> $stable(byte_q));
  assert_squelch_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_present |=> byte_q == '0);
endmodule

// File: rtl/rx_signal_guard.sv
module rx_signal_guard #(
  parameter int RUN_LIMIT = 128,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              los_clr,
  input  logic              sig_present,
  input  logic              rx_byte_tick,
  input  logic              tx_byte_tick,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              los_flag,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_tick
);
  logic fwd_tick;

  rsg_run_watch #(.RUN_LIMIT(RUN_LIMIT)) u_watch (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .clr(los_clr), .los_o(los_flag)
  );

  rsg_tick_select u_sel (
    .clk(clk), .rst_n(rst_n), .sig_present(sig_present),
    .rx_tick(rx_byte_tick), .tx_tick(tx_byte_tick), .fwd_tick(fwd_tick)
  );

  rsg_squelch #(.BYTE_W(BYTE_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .sig_present(sig_present), .fwd_tick(fwd_tick),
    .byte_in(rx_byte), .byte_out(byte_out), .tick_out(byte_tick)
  );

  assert_tick_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_tick |-> $past(rx_byte_tick || tx_byte_tick));
endmodule

// File: tb/rx_signal_guard_tb.sv
module rx_signal_guard_tb;
  localparam int RUN_LIMIT = 128;
  localparam int BYTE_W    = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bit_vld, bit_in, los_clr, sig_present, rx_tick, tx_tick;
  logic [BYTE_W-1:0] rx_byte, byte_out;
  logic los_flag, byte_tick;

  rx_signal_guard #(.RUN_LIMIT(RUN_LIMIT), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .los_clr(los_clr), .sig_present(sig_present), .rx_byte_tick(rx_tick),
    .tx_byte_tick(tx_tick), .rx_byte(rx_byte), .los_flag(los_flag),
    .byte_out(byte_out), .byte_tick(byte_tick)
  );

  typedef struct packed {
    logic              los;
    logic              tick;
    logic [BYTE_W-1:0] dat;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int              m_run = 0;
  logic            m_prev = 1'b0, m_los = 1'b0, m_src = 1'b0;
  logic [BYTE_W-1:0] m_dat = '0;

  task automatic drive(input logic bv, input logic b, input logic clr,
                       input logic sp, input logic rt, input logic tt,
                       input logic [BYTE_W-1:0] d, input string tag);
    logic fwd;
    exp_t e;
    @(negedge clk);
    bit_vld = bv; bit_in = b; los_clr = clr; sig_present = sp;
    rx_tick = rt; tx_tick = tt; rx_byte = d;
    if (clr) begin
      m_run = 0; m_los = 1'b0;
    end else if (bv) begin
      if (b != m_prev) begin
        m_run = 0; m_los = 1'b0;
      end else begin
        if (m_run < RUN_LIMIT) m_run++;
        if (m_run >= RUN_LIMIT) m_los = 1'b1;
      end
    end
    if (bv) m_prev = b;
    if (!sp && !m_src && tt) m_src = 1'b1;
    else if (sp && m_src && rt) m_src = 1'b0;
    fwd = m_src ? tt : rt;
    if (!sp) m_dat = '0;
    else if (fwd) m_dat = d;
    e.los = m_los; e.tick = fwd; e.dat = m_dat;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    exp_t  e;
    string t;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({los_flag, byte_tick, byte_out} !== e) begin
        n_bad++;
        $display("FAIL %s: got los=%0b tick=%0b byte=%02h, expected los=%0b tick=%0b byte=%02h",
                 t, los_flag, byte_tick, byte_out, e.los, e.tick, e.dat);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; los_clr = 1'b0;
    sig_present = 1'b1; rx_tick = 1'b0; tx_tick = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if ({los_flag, byte_tick, byte_out} !== '0) begin
      n_bad++;
      $display("FAIL R1: got los=%0b tick=%0b byte=%02h, expected all zero",
               los_flag, byte_tick, byte_out);
    end
    rst_n = 1'b1;

    // R3: one short of the limit, then a change
    for (int i = 0; i < RUN_LIMIT - 1; i++) drive(1, 0, 0, 1, 0, 0, '0, "R3");
    drive(1, 1, 0, 1, 0, 0, '0, "R4");
    // R6: ignored idle cycles inside a run of ones
    for (int i = 0; i < RUN_LIMIT - 2; i++) drive(1, 1, 0, 1, 0, 0, '0, "R3");
    for (int i = 0; i < 20; i++) drive(0, 0, 0, 1, 0, 0, '0, "R6");
    drive(1, 1, 0, 1, 0, 0, '0, "R6");
    // R2: limit reached, flag rises and stays
    drive(1, 1, 0, 1, 0, 0, '0, "R2");
    drive(1, 1, 0, 1, 0, 0, '0, "R2");
    // R4: a change drops the flag
    drive(1, 0, 0, 1, 0, 0, '0, "R4");
    // R5: clear on the bit that would complete the run
    for (int i = 0; i < RUN_LIMIT - 1; i++) drive(1, 0, 0, 1, 0, 0, '0, "R5");
    drive(1, 0, 1, 1, 0, 0, '0, "R5");
    for (int i = 0; i < RUN_LIMIT - 1; i++) drive(1, 0, 0, 1, 0, 0, '0, "R5");
    drive(1, 0, 0, 1, 0, 0, '0, "R2");
    drive(0, 0, 1, 1, 0, 0, '0, "R5");
    drive(0, 0, 0, 1, 0, 0, '0, "R5");

    // R7: normal byte forwarding on receive strobes
    for (int i = 0; i < 40; i++)
      drive(0, 0, 0, 1, (i % 8) == 0, (i % 8) == 3, 8'(i * 7 + 3), "R7");
    // R8/R9/R10: loss episode and recovery
    for (int i = 0; i < 48; i++)
      drive(0, 0, 0, !(i >= 9 && i < 30), (i % 8) == 0, (i % 8) == 3,
            8'(i * 13 + 5), (i < 9) ? "R7" : (i < 30) ? "R9" : "R10");
    // R8: squelched bytes under varied input
    for (int i = 0; i < 16; i++)
      drive(0, 0, 0, 0, (i % 4) == 1, (i % 4) == 2, 8'(8'hA5 ^ i), "R8");
    for (int i = 0; i < 12; i++)
      drive(0, 0, 0, 1, (i % 4) == 0, 1'b0, 8'(8'h3C + i), "R10");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule